// File: doc/BRIEF.md
# Wishbone Pulse-Handshake Clock-Domain Bridge

This block carries single Wishbone classic read and write cycles from a master in one clock domain to a slave in another, unrelated clock domain. It uses no FIFO. When the source-side master raises cyc and stb, the bridge latches the request into registers in the source domain. It then flips a toggle flop that a synchronizer in the target domain turns into a one-cycle start event. The target side drives the slave from those latched fields until the slave answers with ack or err.

The target side latches the read data and the error flag into its own registers. It then flips a second toggle that the source domain turns back into a completion event. Only then does the source port end the cycle, with exactly one of ack or err. Each latched bundle stays unchanged for as long as the other domain may sample it. This makes a multi-bit crossing safe without per-bit synchronizers.

Only one transaction may be in flight at a time. A source master may give up a cycle by dropping cyc before it completes. The target access still finishes, and the late completion is discarded without any response on the source port.

Top module: `wbx_bridge`

## Requirements
- R1: When the bridge is idle and the source port has cyc and stb high, the target port performs exactly one access. That access uses the source's we, adr, sel and dat_w values.
- R2: During a target access, m_cyc and m_stb stay high and m_we, m_adr, m_sel and m_dat_w stay unchanged until the slave raises m_ack or m_err. There is no timeout. m_cyc drops in the next cycle after the slave responds.
- R3: A read returns the slave's m_dat_r value on s_dat_r in the same cycle as s_ack.
- R4: A write forwards sel unchanged. With sel bit k high, the slave updates only byte k, which is bits 8k+7 down to 8k.
- R5: If the slave answers with m_err, the source port raises s_err and leaves s_ack low.
- R6: s_ack and s_err are never high together. Each one lasts exactly one source clock cycle.
- R7: A new source request is not accepted while a transaction is in flight. A request presented before the previous access completes is started only afterwards, and it returns its own correct data.
- R8: If the source master drops cyc before completion, the target access still runs to its end. No ack or err then appears on the source port.
- R9: Each crossing event yields exactly one receive-side pulse of one cycle, so each source request causes one target access and one source response.
- R10: While either reset is high, s_ack, s_err, m_cyc and m_stb are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| s_cyc | input | 1 | Source master cycle valid |
| s_stb | input | 1 | Source master strobe |
| s_we | input | 1 | Source master write enable |
| s_adr | input | 32 | Source master address |
| s_sel | input | 4 | Source master byte selects |
| s_dat_w | input | 32 | Source master write data |
| s_dat_r | output | 32 | Read data returned to source master |
| s_ack | output | 1 | Normal termination to source master |
| s_err | output | 1 | Error termination to source master |
| dst_clk | input | 1 | Target domain clock |
| dst_rst | input | 1 | Target domain synchronous reset, active high |
| m_cyc | output | 1 | Target cycle valid |
| m_stb | output | 1 | Target strobe |
| m_we | output | 1 | Target write enable |
| m_adr | output | 32 | Target address |
| m_sel | output | 4 | Target byte selects |
| m_dat_w | output | 32 | Target write data |
| m_dat_r | input | 32 | Read data from target slave |
| m_ack | input | 1 | Normal termination from target slave |
| m_err | input | 1 | Error termination from target slave |

## Verification
The bench runs the two sides on unrelated periods. It covers a slave that answers on its first cycle and one that stalls for many cycles. A bridge that released the target strobe early or that sampled changing fields would show up as a wrong address or lost data at the slave. A slave error is checked to return err alone; a design that merged both terminations would raise ack with it. The bench also abandons cycles, once left idle and once followed at once by a fresh request. A bridge that did not discard the late completion would give a stray ack, or would answer the new read with the abandoned access's data.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    localparam int unsigned SEL_W = DATA_W / 8;

    // Request bundle held static in the source domain while crossing
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] dat;
    } wbx_req_t;

    // Response bundle held static in the target domain while crossing
    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] dat;
    } wbx_rsp_t;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_BUSY = 2'd1,
        SRC_DONE = 2'd2
    } src_state_e;

    typedef enum logic {
        DST_IDLE   = 1'b0,
        DST_ACCESS = 1'b1
    } dst_state_e;

    function automatic logic wbx_active(input logic cyc, input logic stb);
        return cyc & stb;
    endfunction

endpackage

// File: rtl/wbx_pulse_sync.sv
module wbx_pulse_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic snd_clk,
    input  logic snd_rst,
    input  logic snd_pulse,
    input  logic rcv_clk,
    input  logic rcv_rst,
    output logic rcv_pulse
);

    logic              tog_q;
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Sending side: one level change per event
    always_ff @(posedge snd_clk) begin
        if (snd_rst)        tog_q <= 1'b0;
        else if (snd_pulse) tog_q <= ~tog_q;
    end

    // Receiving side: multi-flop synchronizer plus edge detector
    always_ff @(posedge rcv_clk) begin
        if (rcv_rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tog_q};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rcv_pulse = sync_q[STAGES-1] ^ last_q;

    // R9: an event surfaces as a single-cycle pulse
    assert_pulse_single_R9: assert property (@(posedge rcv_clk) disable iff (rcv_rst)
        rcv_pulse |=> !rcv_pulse);

endmodule

// File: rtl/wbx_src_side.sv
module wbx_src_side
    import wbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cyc,
    input  logic                stb,
    input  logic                we,
    input  logic [ADDR_W-1:0]   adr,
    input  logic [SEL_W-1:0]    sel,
    input  logic [DATA_W-1:0]   dat_w,
    output logic [DATA_W-1:0]   dat_r,
    output logic                ack,
    output logic                err,
    output logic                start_pulse,
    output wbx_req_t            req,
    input  logic                done_pulse,
    input  wbx_rsp_t            rsp
);

    src_state_e        state_q;
    logic              abandon_q;
    wbx_req_t          req_q;
    logic              ack_q;
    logic              err_q;
    logic [DATA_W-1:0] dat_q;

    always_comb start_pulse = (state_q == SRC_IDLE) && wbx_active(cyc, stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SRC_IDLE;
            abandon_q <= 1'b0;
            req_q     <= '0;
            ack_q     <= 1'b0;
            err_q     <= 1'b0;
            dat_q     <= '0;
        end else begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            unique case (state_q)
                SRC_IDLE: begin
                    if (start_pulse) begin
                        req_q     <= '{we: we, adr: adr, sel: sel, dat: dat_w};
                        abandon_q <= 1'b0;
                        state_q   <= SRC_BUSY;
                    end
                end
                SRC_BUSY: begin
                    if (done_pulse) begin
                        if (abandon_q || !wbx_active(cyc, stb)) begin
                            state_q <= SRC_IDLE;
                        end else begin
                            ack_q   <= ~rsp.err;
                            err_q   <= rsp.err;
                            dat_q   <= rsp.dat;
                            state_q <= SRC_DONE;
                        end
                    end else if (!cyc) begin
                        abandon_q <= 1'b1;
                    end
                end
                SRC_DONE: state_q <= SRC_IDLE;
                default:  state_q <= SRC_IDLE;
            endcase
        end
    end

    assign req   = req_q;
    assign ack   = ack_q;
    assign err   = err_q;
    assign dat_r = dat_q;

    // R6: terminations are exclusive
    assert_ack_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(ack && err));

    // R6: a termination lasts a single cycle
    assert_term_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (ack || err) |=> !(ack || err));

endmodule

// File: rtl/wbx_dst_side.sv
module wbx_dst_side
    import wbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_pulse,
    input  wbx_req_t            req,
    output logic                m_cyc,
    output logic                m_stb,
    output logic                m_we,
    output logic [ADDR_W-1:0]   m_adr,
    output logic [SEL_W-1:0]    m_sel,
    output logic [DATA_W-1:0]   m_dat_w,
    input  logic [DATA_W-1:0]   m_dat_r,
    input  logic                m_ack,
    input  logic                m_err,
    output logic                done_pulse,
    output wbx_rsp_t            rsp
);

    dst_state_e state_q;
    wbx_rsp_t   rsp_q;

    always_comb done_pulse = (state_q == DST_ACCESS) && (m_ack || m_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DST_IDLE;
            rsp_q   <= '0;
        end else begin
            unique case (state_q)
                DST_IDLE: begin
                    if (start_pulse) state_q <= DST_ACCESS;
                end
                DST_ACCESS: begin
                    if (done_pulse) begin
                        rsp_q   <= '{err: m_err, dat: m_dat_r};
                        state_q <= DST_IDLE;
                    end
                end
                default: state_q <= DST_IDLE;
            endcase
        end
    end

    // Request fields come straight from the static source-domain bundle
    assign m_cyc   = (state_q == DST_ACCESS);
    assign m_stb   = (state_q == DST_ACCESS);
    assign m_we    = req.we;
    assign m_adr   = req.adr;
    assign m_sel   = req.sel;
    assign m_dat_w = req.dat;
    assign rsp     = rsp_q;

    // R2: the access is held until the slave answers
    assert_hold_until_resp_R2: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && !(m_ack || m_err)) |=> m_cyc);

    // R2: crossed fields do not move during an access
    assert_fields_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && $past(m_cyc)) |-> ($stable(m_adr) && $stable(m_dat_w)
                                     && $stable(m_sel) && $stable(m_we)));

endmodule

// File: rtl/wbx_bridge.sv
module wbx_bridge
    import wbx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              s_cyc,
    input  logic              s_stb,
    input  logic              s_we,
    input  logic [31:0]       s_adr,
    input  logic [3:0]        s_sel,
    input  logic [31:0]       s_dat_w,
    output logic [31:0]       s_dat_r,
    output logic              s_ack,
    output logic              s_err,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic              m_cyc,
    output logic              m_stb,
    output logic              m_we,
    output logic [31:0]       m_adr,
    output logic [3:0]        m_sel,
    output logic [31:0]       m_dat_w,
    input  logic [31:0]       m_dat_r,
    input  logic              m_ack,
    input  logic              m_err
);

    logic     start_src;
    logic     start_dst;
    logic     done_dst;
    logic     done_src;
    wbx_req_t req_bus;
    wbx_rsp_t rsp_bus;

    wbx_src_side u_src (
        .clk         (src_clk),
        .rst         (src_rst),
        .cyc         (s_cyc),
        .stb         (s_stb),
        .we          (s_we),
        .adr         (s_adr),
        .sel         (s_sel),
        .dat_w       (s_dat_w),
        .dat_r       (s_dat_r),
        .ack         (s_ack),
        .err         (s_err),
        .start_pulse (start_src),
        .req         (req_bus),
        .done_pulse  (done_src),
        .rsp         (rsp_bus)
    );

    wbx_pulse_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .snd_clk   (src_clk),
        .snd_rst   (src_rst),
        .snd_pulse (start_src),
        .rcv_clk   (dst_clk),
        .rcv_rst   (dst_rst),
        .rcv_pulse (start_dst)
    );

    wbx_dst_side u_dst (
        .clk         (dst_clk),
        .rst         (dst_rst),
        .start_pulse (start_dst),
        .req         (req_bus),
        .m_cyc       (m_cyc),
        .m_stb       (m_stb),
        .m_we        (m_we),
        .m_adr       (m_adr),
        .m_sel       (m_sel),
        .m_dat_w     (m_dat_w),
        .m_dat_r     (m_dat_r),
        .m_ack       (m_ack),
        .m_err       (m_err),
        .done_pulse  (done_dst),
        .rsp         (rsp_bus)
    );

    wbx_pulse_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .snd_clk   (dst_clk),
        .snd_rst   (dst_rst),
        .snd_pulse (done_dst),
        .rcv_clk   (src_clk),
        .rcv_rst   (src_rst),
        .rcv_pulse (done_src)
    );

endmodule

// File: tb/wbx_bridge_test.sv
`timescale 1ns/1ps
module wbx_bridge_test;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst = 1'b1;
    logic dst_rst = 1'b1;
    always #10   src_clk = ~src_clk;   // 50 MHz source side
    always #6.5  dst_clk = ~dst_clk;   // unrelated target side

    logic        s_cyc = 0, s_stb = 0, s_we = 0;
    logic [31:0] s_adr = 0, s_dat_w = 0;
    logic [3:0]  s_sel = 0;
    logic [31:0] s_dat_r;
    logic        s_ack, s_err;
    logic        m_cyc, m_stb, m_we;
    logic [31:0] m_adr, m_dat_w;
    logic [3:0]  m_sel;
    logic [31:0] m_dat_r;
    logic        m_ack, m_err;

    wbx_bridge uut (
        .src_clk(src_clk), .src_rst(src_rst),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_sel(s_sel), .s_dat_w(s_dat_w), .s_dat_r(s_dat_r),
        .s_ack(s_ack), .s_err(s_err),
        .dst_clk(dst_clk), .dst_rst(dst_rst),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr),
        .m_sel(m_sel), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r),
        .m_ack(m_ack), .m_err(m_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- target slave model ----------------
    // 16 words at adr[5:2]; adr[31:28]==4'hE answers with err
    logic [31:0] mem [16];
    int          slv_lat = 0;
    int          slv_cnt = 0;
    int          slv_acc = 0;
    int          hold_bad = 0;
    logic        ack_r = 0, err_r = 0;
    logic [31:0] rd_r = 0;
    logic        f_we;
    logic [31:0] f_adr, f_dat;
    logic [3:0]  f_sel;
    logic        l_we;
    logic [31:0] l_adr, l_dat;
    logic [3:0]  l_sel;

    assign m_ack   = ack_r;
    assign m_err   = err_r;
    assign m_dat_r = rd_r;

    always @(posedge dst_clk) begin
        if (dst_rst) begin
            ack_r <= 0; err_r <= 0; slv_cnt <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
        end else begin
            ack_r <= 0;
            err_r <= 0;
            if (m_cyc && m_stb && !ack_r && !err_r) begin
                if (slv_cnt == 0) begin
                    f_we <= m_we; f_adr <= m_adr; f_sel <= m_sel; f_dat <= m_dat_w;
                end
                if (slv_cnt >= slv_lat) begin
                    slv_cnt <= 0;
                    slv_acc <= slv_acc + 1;
                    l_we <= m_we; l_adr <= m_adr; l_sel <= m_sel; l_dat <= m_dat_w;
                    if (slv_cnt != 0 && (m_adr != f_adr || m_dat_w != f_dat ||
                                         m_sel != f_sel || m_we != f_we))
                        hold_bad <= hold_bad + 1;
                    if (m_adr[31:28] == 4'hE) begin
                        err_r <= 1;
                        rd_r  <= 32'hDEAD_0000;
                    end else begin
                        ack_r <= 1;
                        if (m_we) begin
                            for (int b = 0; b < 4; b++)
                                if (m_sel[b]) mem[m_adr[5:2]][8*b +: 8] <= m_dat_w[8*b +: 8];
                        end else begin
                            rd_r <= mem[m_adr[5:2]];
                        end
                    end
                end else begin
                    slv_cnt <= slv_cnt + 1;
                end
            end
        end
    end

    // ---------------- source-side monitors ----------------
    int both_cnt = 0;
    int resp_seen = 0;
    always @(negedge src_clk) begin
        if (!src_rst) begin
            if (s_ack && s_err) both_cnt <= both_cnt + 1;
            if (s_ack || s_err) resp_seen <= resp_seen + 1;
        end
    end

    // ---------------- master transfer ----------------
    task automatic xfer(input bit we, input logic [31:0] adr, input logic [3:0] sel,
                        input logic [31:0] d, output logic [31:0] rd,
                        output bit got_ack, output bit got_err, output bit stuck);
        @(negedge src_clk);
        s_cyc = 1; s_stb = 1; s_we = we; s_adr = adr; s_sel = sel; s_dat_w = d;
        got_ack = 0; got_err = 0; stuck = 1; rd = '0;
        for (int i = 0; i < 400; i++) begin
            @(negedge src_clk);
            if (s_ack || s_err) begin
                got_ack = s_ack; got_err = s_err; rd = s_dat_r; stuck = 0;
                break;
            end
        end
        s_cyc = 0; s_stb = 0;
        @(negedge src_clk);
        chk(!(s_ack || s_err), "R6", "termination held longer than one cycle",
            {31'b0, s_ack | s_err}, 32'h0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge src_clk);
        chk(!s_ack && !s_err, "R10", "source terminations during reset", {s_ack, s_err}, 0);
        chk(!m_cyc && !m_stb, "R10", "target cycle during reset", {m_cyc, m_stb}, 0);
    endtask

    task automatic t_write_read();
        logic [31:0] rd; bit a, e, s; int acc0;
        slv_lat = 2;
        acc0 = slv_acc;
        xfer(1, 32'h0000_0010, 4'hF, 32'hA5A5_1234, rd, a, e, s);
        chk(a && !e && !s, "R1", "write termination", {a, e, s}, 3'b100);
        chk(slv_acc == acc0 + 1, "R9", "target accesses per write", slv_acc - acc0, 1);
        chk(l_we && l_adr == 32'h10 && l_sel == 4'hF && l_dat == 32'hA5A5_1234,
            "R1", "fields seen at slave", l_adr, 32'h10);
        xfer(0, 32'h0000_0010, 4'hF, 32'h0, rd, a, e, s);
        chk(a && !e && !s, "R3", "read termination", {a, e, s}, 3'b100);
        chk(rd == 32'hA5A5_1234, "R3", "read data", rd, 32'hA5A5_1234);
        chk(!l_we, "R1", "read seen as read at slave", l_we, 0);
        chk(slv_acc == acc0 + 2, "R9", "target accesses after read", slv_acc - acc0, 2);
    endtask

    task automatic t_sel_write();
        logic [31:0] rd; bit a, e, s;
        slv_lat = 1;
        xfer(1, 32'h0000_0020, 4'hF, 32'hFFFF_FFFF, rd, a, e, s);
        xfer(1, 32'h0000_0020, 4'b0101, 32'h1234_5678, rd, a, e, s);
        chk(l_sel == 4'b0101, "R4", "sel at slave", l_sel, 4'b0101);
        xfer(0, 32'h0000_0020, 4'hF, 32'h0, rd, a, e, s);
        chk(rd == 32'hFF34_FF78, "R4", "masked write result", rd, 32'hFF34_FF78);
    endtask

    task automatic t_error();
        logic [31:0] rd; bit a, e, s;
        slv_lat = 3;
        xfer(0, 32'hE000_0004, 4'hF, 32'h0, rd, a, e, s);
        chk(e && !a && !s, "R5", "slave error gives err alone", {a, e, s}, 3'b010);
        xfer(0, 32'h0000_0010, 4'hF, 32'h0, rd, a, e, s);
        chk(a && !e && rd == 32'hA5A5_1234, "R5", "normal read after error", rd, 32'hA5A5_1234);
    endtask

    task automatic t_latency();
        logic [31:0] rd; bit a, e, s;
        slv_lat = 0;
        xfer(1, 32'h0000_0030, 4'hF, 32'h0BAD_F00D, rd, a, e, s);
        chk(a && !s, "R2", "zero-wait slave write", {a, s}, 2'b10);
        slv_lat = 25;
        xfer(0, 32'h0000_0030, 4'hF, 32'h0, rd, a, e, s);
        chk(a && !s && rd == 32'h0BAD_F00D, "R2", "long-stall slave read", rd, 32'h0BAD_F00D);
        chk(hold_bad == 0, "R2", "fields changed during stalled access", hold_bad, 0);
        @(negedge dst_clk);
        chk(!m_cyc, "R2", "target cycle released after response", m_cyc, 0);
    endtask

    task automatic t_abandon();
        logic [31:0] rd; bit a, e, s; int acc0, seen0;
        slv_lat = 15;
        acc0 = slv_acc; seen0 = resp_seen;
        @(negedge src_clk);
        s_cyc = 1; s_stb = 1; s_we = 1; s_adr = 32'h0000_0004; s_sel = 4'hF; s_dat_w = 32'h5555_AAAA;
        repeat (2) @(negedge src_clk);
        s_cyc = 0; s_stb = 0;
        repeat (60) @(negedge src_clk);
        chk(resp_seen == seen0, "R8", "response after abandoned cycle", resp_seen - seen0, 0);
        chk(slv_acc == acc0 + 1, "R8", "abandoned access still run", slv_acc - acc0, 1);
        // abandon, then request at once while the first is still in flight
        @(negedge src_clk);
        s_cyc = 1; s_stb = 1; s_we = 1; s_adr = 32'h0000_0008; s_sel = 4'hF; s_dat_w = 32'h1111_2222;
        repeat (2) @(negedge src_clk);
        s_cyc = 0; s_stb = 0;
        xfer(0, 32'h0000_0004, 4'hF, 32'h0, rd, a, e, s);
        chk(a && !s && rd == 32'h5555_AAAA, "R7", "read queued behind abandoned write", rd, 32'h5555_AAAA);
        slv_lat = 0;
        xfer(0, 32'h0000_0008, 4'hF, 32'h0, rd, a, e, s);
        chk(rd == 32'h1111_2222, "R8", "abandoned write landed", rd, 32'h1111_2222);
        chk(slv_acc == acc0 + 4, "R7", "target access count", slv_acc - acc0, 4);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge src_clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge src_clk);
        t_reset();
        repeat (2) @(negedge src_clk);
        src_rst = 0;
        dst_rst = 0;
        repeat (3) @(negedge src_clk);
        t_write_read();
        t_sel_write();
        t_error();
        t_latency();
        t_abandon();
        chk(both_cnt == 0, "R6", "ack and err together", both_cnt, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule